// File: doc/BRIEF.md
# Transmit DMA Channel Teardown Controller

This block runs host-commanded teardown for a bank of transmit DMA channels (eight by default). The host names the channel to shut down on a small command stream. The block keeps one head-descriptor pointer per channel. A non-zero pointer means the channel has work queued. If a frame is still leaving on that channel, the teardown waits until the transmit engine drops that channel's busy flag.

After that wait, an active channel sends one writeback request to the descriptor writer. The request carries the channel number and the address of its next start-of-packet descriptor, and it asks the writer to set the teardown-complete flag in that descriptor. When the memory side grants the request, the head pointer is cleared. An inactive channel skips the writeback entirely.

In both cases the channel's interrupt line then rises and stays high until the host writes the acknowledge word 0xFFFFFFFC for that channel. While the interrupt is pending, reading the acknowledge location returns that same word. Channel enable bits belong to the host, and the teardown logic never changes them.

The command stream uses valid/ready. `cmd_ready` is always high, so the block never back-pressures, and a beat is taken on every cycle where `cmd_valid` is high. The writeback port is a request/grant pair. Once `wb_valid` is raised, `wb_chan` and `wb_addr` hold steady until a cycle with `wb_ready` high completes the transfer.

Top module: `txdma_teardown_ctrl`

## Requirements
- R1: A command to a channel with no teardown in progress starts one. A command to a channel whose teardown is already in progress (waiting, writing back, or interrupt pending) is ignored. `cmd_ready` reads 1 at all times.
- R2: While the channel's `frame_busy` bit is 1, no writeback is requested and no interrupt is raised for that channel.
- R3: An active channel (head pointer non-zero) that is not busy requests a writeback the cycle after its command, or the cycle after `frame_busy` falls. The request carries `wb_chan` equal to the channel and `wb_addr` equal to its head pointer, and both hold steady while `wb_ready` is 0.
- R4: The cycle after a writeback is granted, the channel's head pointer reads 0 and its interrupt is 1.
- R5: An inactive channel (head pointer 0) makes no writeback request, and its interrupt rises the cycle after the command, or the cycle after `frame_busy` falls.
- R6: A pending interrupt stays 1 until an acknowledge write of 0xFFFFFFFC to that channel. A write of any other value, or a write to another channel, leaves it pending. The line drops the cycle after a matching acknowledge.
- R7: `ack_rd_data` returns 0xFFFFFFFC for the channel selected by `rd_chan` while that channel's teardown interrupt is pending, and 0 otherwise.
- R8: A teardown never changes `chan_en`. Only an enable write changes it.
- R9: Head-pointer writes to a channel are ignored while its teardown is in progress.
- R10: When several channels request writebacks, the highest channel number is served first, unless a request is already being held for a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Teardown command beat valid |
| cmd_ready | output | 1 | Always 1 |
| cmd_chan | input | 3 | Channel to tear down |
| hdp_wr_en | input | 1 | Head-pointer write strobe |
| hdp_wr_chan | input | 3 | Head-pointer write channel |
| hdp_wr_data | input | 32 | Head-pointer write value |
| en_wr | input | 1 | Channel-enable write strobe |
| en_wdata | input | 8 | New channel-enable bits |
| chan_en | output | 8 | Channel-enable bits |
| frame_busy | input | 8 | Per-channel frame-in-flight flags |
| wb_valid | output | 1 | Descriptor writeback request |
| wb_ready | input | 1 | Writeback grant |
| wb_chan | output | 3 | Channel of the writeback |
| wb_addr | output | 32 | Start-of-packet descriptor address to flag |
| irq | output | 8 | Per-channel teardown interrupts |
| ack_wr_en | input | 1 | Acknowledge write strobe |
| ack_chan | input | 3 | Acknowledge channel |
| ack_data | input | 32 | Acknowledge value |
| rd_chan | input | 3 | Channel for read-back |
| hdp_rd_data | output | 32 | Head pointer of `rd_chan` |
| ack_rd_data | output | 32 | Acknowledge read-back of `rd_chan` |

## Verification
The assertions check several properties on every cycle:
- a waiting channel stays put while its frame is busy;
- interrupts stay pending until a matching acknowledge and clear right after one;
- a held writeback request keeps its channel steady until granted;
- grants are one-hot and only reach a channel in the writeback state;
- a granted head pointer reads zero next;
- head pointers stay frozen during teardown;
- the enables change only on an enable write.

The bench scenarios cover the rest:
- the address carried on the writeback;
- the exact cycle the interrupt rises on the active and inactive paths;
- rejection of wrong acknowledge words and of duplicate commands;
- the read-back value;
- highest-channel-first service when two channels finish waiting together.

// File: rtl/tdn_pkg.sv
package tdn_pkg;
  typedef enum logic [1:0] {
    TD_IDLE = 2'd0,
    TD_WAIT = 2'd1,
    TD_WB   = 2'd2,
    TD_IRQ  = 2'd3
  } td_state_e;

  localparam logic [31:0] TD_ACK_MAGIC = 32'hFFFF_FFFC;
endpackage

// File: rtl/tdn_chan_fsm.sv
module tdn_chan_fsm
  import tdn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_hit,
  input  logic      frame_busy,
  input  logic      hdp_nonzero,
  input  logic      wb_grant,
  input  logic      ack_hit,
  output td_state_e state,
  output logic      wb_req,
  output logic      irq,
  output logic      clr_hdp
);
  td_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      TD_IDLE: if (cmd_hit) begin
        if (frame_busy)       state_d = TD_WAIT;
        else if (hdp_nonzero) state_d = TD_WB;
        else                  state_d = TD_IRQ;
      end
      TD_WAIT: if (!frame_busy) state_d = hdp_nonzero ? TD_WB : TD_IRQ;
      TD_WB:   if (wb_grant) state_d = TD_IRQ;
      TD_IRQ:  if (ack_hit)  state_d = TD_IDLE;
      default: state_d = TD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= TD_IDLE;
    else        state <= state_d;
  end

  assign wb_req  = (state == TD_WB);
  assign irq     = (state == TD_IRQ);
  assign clr_hdp = (state == TD_WB) && wb_grant;

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TD_WAIT && frame_busy) |=> (state == TD_WAIT)); // R2
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_hit) |=> irq); // R6
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack_hit) |=> !irq); // R6
  AST_DUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && state == TD_WB && !wb_grant) |=> (state == TD_WB)); // R1
  AST_GRANT_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_grant |-> (state == TD_WB)); // R3
endmodule

// File: rtl/tdn_wb_arb.sv
module tdn_wb_arb #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [CH_W-1:0]   sel,
  output logic [NUM_CH-1:0] grant
);
  logic            lock_q;
  logic [CH_W-1:0] lock_idx_q;
  logic [CH_W-1:0] top_idx;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i]) top_idx = CH_W'(i);
    end
  end

  assign sel      = lock_q ? lock_idx_q : top_idx;
  assign wb_valid = |req;

  always_comb begin
    grant = '0;
    if (wb_valid && wb_ready) grant[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= wb_valid && !wb_ready;
      lock_idx_q <= sel;
    end
  end

  AST_WB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(sel))); // R3
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10
  AST_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !lock_q) |-> ((req >> sel) == NUM_CH'(1))); // R10
endmodule

// File: rtl/txdma_teardown_ctrl.sv
module txdma_teardown_ctrl
  import tdn_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic              hdp_wr_en,
  input  logic [CH_W-1:0]   hdp_wr_chan,
  input  logic [PTR_W-1:0]  hdp_wr_data,
  input  logic              en_wr,
  input  logic [NUM_CH-1:0] en_wdata,
  output logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] frame_busy,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [CH_W-1:0]   wb_chan,
  output logic [PTR_W-1:0]  wb_addr,
  output logic [NUM_CH-1:0] irq,
  input  logic              ack_wr_en,
  input  logic [CH_W-1:0]   ack_chan,
  input  logic [31:0]       ack_data,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [PTR_W-1:0]  hdp_rd_data,
  output logic [31:0]       ack_rd_data
);
  logic [PTR_W-1:0]  hdp_q [NUM_CH];
  td_state_e         st    [NUM_CH];
  logic [NUM_CH-1:0] wb_req;
  logic [NUM_CH-1:0] grant;
  logic [NUM_CH-1:0] clr_hdp;
  logic              ack_magic;

  assign cmd_ready = 1'b1;
  assign ack_magic = ack_wr_en && (ack_data == TD_ACK_MAGIC);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic cmd_hit, ack_hit, hdp_we;

    assign cmd_hit = cmd_valid && (cmd_chan == CH_W'(g));
    assign ack_hit = ack_magic && (ack_chan == CH_W'(g));
    assign hdp_we  = hdp_wr_en && (hdp_wr_chan == CH_W'(g)) && (st[g] == TD_IDLE);

    tdn_chan_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_hit     (cmd_hit),
      .frame_busy  (frame_busy[g]),
      .hdp_nonzero (hdp_q[g] != '0),
      .wb_grant    (grant[g]),
      .ack_hit     (ack_hit),
      .state       (st[g]),
      .wb_req      (wb_req[g]),
      .irq         (irq[g]),
      .clr_hdp     (clr_hdp[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)          hdp_q[g] <= '0;
      else if (clr_hdp[g]) hdp_q[g] <= '0;
      else if (hdp_we)     hdp_q[g] <= hdp_wr_data;
    end

    AST_HDP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hdp[g] |=> (hdp_q[g] == '0)); // R4
    AST_HDP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] != TD_IDLE && !clr_hdp[g]) |=> $stable(hdp_q[g])); // R9
  end

  tdn_wb_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (wb_req),
    .wb_ready (wb_ready),
    .wb_valid (wb_valid),
    .sel      (wb_chan),
    .grant    (grant)
  );

  assign wb_addr     = hdp_q[wb_chan];
  assign hdp_rd_data = hdp_q[rd_chan];
  assign ack_rd_data = irq[rd_chan] ? TD_ACK_MAGIC : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n)     chan_en <= '0;
    else if (en_wr) chan_en <= en_wdata;
  end

  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(chan_en)); // R8
  AST_WB_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> $stable(wb_addr)); // R3
endmodule

// File: tb/txdma_teardown_ctrl_tb.sv
`timescale 1ns/1ps
module txdma_teardown_ctrl_tb;
  localparam logic [31:0] MAGIC = 32'hFFFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_ready;
  logic [2:0]  cmd_chan = 0;
  logic        hdp_wr_en = 0;
  logic [2:0]  hdp_wr_chan = 0;
  logic [31:0] hdp_wr_data = 0;
  logic        en_wr = 0;
  logic [7:0]  en_wdata = 0, chan_en;
  logic [7:0]  frame_busy = 0;
  logic        wb_valid, wb_ready = 0;
  logic [2:0]  wb_chan;
  logic [31:0] wb_addr;
  logic [7:0]  irq;
  logic        ack_wr_en = 0;
  logic [2:0]  ack_chan = 0;
  logic [31:0] ack_data = 0;
  logic [2:0]  rd_chan = 0;
  logic [31:0] hdp_rd_data, ack_rd_data;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  txdma_teardown_ctrl u_dut (.*);

  function automatic logic [31:0] exp_ack_rd(input bit pending);
    return pending ? MAGIC : 32'h0;
  endfunction

  function automatic logic [31:0] make_ptr(input logic [31:0] r);
    return {r[31:4], 4'h0} | 32'h0000_0100;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic set_hdp(input logic [2:0] ch, input logic [31:0] v);
    hdp_wr_en = 1; hdp_wr_chan = ch; hdp_wr_data = v; tick(); hdp_wr_en = 0;
  endtask

  task automatic send_cmd(input logic [2:0] ch);
    cmd_valid = 1; cmd_chan = ch; tick(); cmd_valid = 0;
  endtask

  task automatic send_ack(input logic [2:0] ch, input logic [31:0] v);
    ack_wr_en = 1; ack_chan = ch; ack_data = v; tick(); ack_wr_en = 0;
  endtask

  task automatic random_teardown();
    logic [2:0]  ch;
    logic [31:0] ptr, bad;
    int          busy_n, stall_n;
    ch      = 3'($urandom % 8);
    ptr     = ($urandom % 4 == 0) ? 32'h0 : make_ptr($urandom);
    busy_n  = $urandom % 4;
    stall_n = $urandom % 3;
    rd_chan = ch;
    set_hdp(ch, ptr);
    frame_busy[ch] = (busy_n != 0);
    send_cmd(ch);
    if (busy_n != 0) begin
      for (int k = 0; k < busy_n; k++) begin
        chk("R2 no wb while busy", 32'(wb_valid), 32'h0);
        chk("R2 no irq while busy", 32'(irq[ch]), 32'h0);
        tick();
      end
      frame_busy[ch] = 0;
      tick();
    end
    if (ptr != 0) begin
      for (int k = 0; k <= stall_n; k++) begin
        chk("R3 wb_valid", 32'(wb_valid), 32'h1);
        chk("R3 wb_chan", 32'(wb_chan), 32'(ch));
        chk("R3 wb_addr", wb_addr, ptr);
        if (k < stall_n) tick();
      end
      wb_ready = 1; tick(); wb_ready = 0;
      chk("R4 hdp zeroed", hdp_rd_data, 32'h0);
    end else begin
      chk("R5 no wb inactive", 32'(wb_valid), 32'h0);
    end
    chk(ptr != 0 ? "R4 irq after wb" : "R5 irq inactive", 32'(irq[ch]), 32'h1);
    chk("R7 ack read pending", ack_rd_data, exp_ack_rd(1'b1));
    if ($urandom % 2 == 1) begin
      bad = $urandom;
      if (bad == MAGIC) bad = 32'h0;
      send_ack(ch, bad);
      chk("R6 wrong ack keeps irq", 32'(irq[ch]), 32'h1);
    end
    send_ack(ch, MAGIC);
    chk("R6 irq cleared", 32'(irq[ch]), 32'h0);
    chk("R7 ack read idle", ack_rd_data, exp_ack_rd(1'b0));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst_n = 1; tick();

    chk("R1 reset ready", 32'(cmd_ready), 32'h1);
    chk("R6 reset irq", 32'(irq), 32'h0);
    chk("R3 reset wb", 32'(wb_valid), 32'h0);
    chk("R7 reset ack read", ack_rd_data, 32'h0);

    en_wr = 1; en_wdata = 8'hA5; tick(); en_wr = 0;

    // R1: duplicate command while pending is ignored
    rd_chan = 3'd3;
    set_hdp(3'd3, 32'h0000_1230);
    send_cmd(3'd3);
    send_cmd(3'd3);
    chk("R1 dup wb chan", 32'(wb_chan), 32'd3);
    wb_ready = 1; tick(); wb_ready = 0;
    send_cmd(3'd3);
    chk("R1 dup no second wb", 32'(wb_valid), 32'h0);
    send_ack(3'd3, MAGIC);
    chk("R1 back to idle", 32'(irq[3]), 32'h0);

    // R9: head-pointer write during teardown ignored
    rd_chan = 3'd1;
    set_hdp(3'd1, 32'h0000_4400);
    frame_busy[1] = 1;
    send_cmd(3'd1);
    set_hdp(3'd1, 32'h0000_9900);
    chk("R9 hdp write ignored", hdp_rd_data, 32'h0000_4400);
    frame_busy[1] = 0; tick();
    wb_ready = 1; tick(); wb_ready = 0;
    send_ack(3'd4, MAGIC);
    chk("R6 other-chan ack keeps irq", 32'(irq[1]), 32'h1);
    send_ack(3'd1, MAGIC);

    // R10: two channels released together, highest first
    set_hdp(3'd2, 32'h0000_2000);
    set_hdp(3'd6, 32'h0000_6000);
    frame_busy[2] = 1; frame_busy[6] = 1;
    send_cmd(3'd2);
    send_cmd(3'd6);
    frame_busy[2] = 0; frame_busy[6] = 0; tick();
    chk("R10 high chan first", 32'(wb_chan), 32'd6);
    chk("R10 high addr", wb_addr, 32'h0000_6000);
    wb_ready = 1; tick(); wb_ready = 0;
    chk("R10 then low chan", 32'(wb_chan), 32'd2);
    chk("R10 low addr", wb_addr, 32'h0000_2000);
    wb_ready = 1; tick(); wb_ready = 0;
    chk("R4 both irqs", 32'(irq), 32'h44);
    send_ack(3'd6, MAGIC);
    send_ack(3'd2, MAGIC);

    for (int n = 0; n < 60; n++) random_teardown();

    chk("R8 enables kept", 32'(chan_en), 32'hA5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule